// File: doc/BRIEF.md
# Indexed Configuration Register File

This block is a small bank of byte-wide control registers that sits in a processor's on-chip configuration space. Software reaches it with an index byte and separate read and write strobes. A write takes effect on the rising clock edge. A read returns the selected register on the read-data bus in the same cycle. Unselected or unknown indices read as zero.

Three of the registers form the mapped group, and a map-enable input gates all access to them:
- The recovery/control register holds the instruction-identify enable, the interrupt-nest bit, the fast-mode bit, the table-cache bit, the read-bypass bit and the 3-bit I/O recovery code.
- The interrupt/extension register holds a bit that raises a non-maskable interrupt request and a bit that enables the extended multimedia instructions.
- The performance register holds the bit that forces loads and stores into program order.

Reserved bits in the mapped group are discarded on write and always read back their fixed values.

A second group holds the protected system-management state. This is an SMM control register (lock, SMAC and USE_SMI bits) and the bytes of the protected region address. Once the lock bit is set, the protected fields can only be changed while the core reports that it is in SMM. The lock itself can only be cleared by reset. The protected state leaves the block as one packed bus. The non-maskable interrupt request is a one-cycle pulse raised only on a 0-to-1 change of its register bit.

Top module: `cfg_regbank`

## Requirements
- R1: After reset, reads with map_en=1 return E8h→85h, EBh→00h, 20h→20h (bit 5 fixed at 1, bit 7 cleared), C1h→00h and C4h..C7h→00h; recov_ctl=85h, ext_en=0, ls_serial=0, smm_prot=0.
- R2: When map_en=0, a write to E8h, EBh or 20h changes nothing (and raises no nmi_req), and a read of those indices returns 00h.
- R3: With map_en=1, all 8 bits of the register at E8h are writable and read back as written; recov_ctl always shows its value.
- R4: In the register at EBh only bit 0 (extension enable, driven on ext_en) and bit 2 (interrupt request bit) are stored; bits 7:3 and bit 1 always read 0.
- R5: In the register at 20h only bit 7 (load/store ordering, driven on ls_serial) is stored; bit 5 always reads 1 and bits 6 and 4:0 always read 0.
- R6: nmi_req is high, in the same cycle, exactly when an accepted write to EBh carries bit 2 = 1 while the stored bit 2 is 0. If the bit is already 1, a write of 1 gives no pulse.
- R7: The SMM control register at C1h has bit 0 = lock, bit 1 = USE_SMI and bit 2 = SMAC, with bits 7:3 reading 0. Writing 1 sets the lock. Writing 0 never clears it, in or out of SMM. Only reset clears it.
- R8: While the lock is 1 and in_smm=0, writes to bits 1 and 2 of C1h and to the address bytes C4h..C7h are ignored. With in_smm=1 they take effect. The lock is 0 after reset, so they are writable until it is set.
- R9: smm_prot = {lock, SMAC, USE_SMI, address}, where the address byte at C4h forms bits 7:0 and C7h forms bits 31:24. The SMM registers are reachable whatever the value of map_en.
- R10: A read of an index outside the listed ones returns 00h, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idx | input | 8 | Register index |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_wdata | input | 8 | Write data |
| map_en | input | 1 | Enables access to the mapped group |
| in_smm | input | 1 | Core is executing in SMM |
| cfg_rdata | output | 8 | Read data, zero when no readable register is selected |
| recov_ctl | output | 8 | Current value of the recovery/control register |
| ext_en | output | 1 | Extended multimedia instruction enable |
| ls_serial | output | 1 | Load/store program-order enable |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| smm_prot | output | 35 | Packed protected SMM state |

## Verification
The bench builds the block with its default parameters:
- an 8-bit index and 8-bit data;
- four address bytes;
- the default index map.

This places the full 35-bit protected bus and every address byte within reach, so locking and unlocking can be observed on each byte and on both control bits. With those values the mapped and unmapped indices lie far apart, so the tests on map gating and on unknown indices probe neighbouring codes as well.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   // slot numbering inside the bank
   localparam int SLOT_A        = 0;
   localparam int SLOT_B        = 1;
   localparam int SLOT_P        = 2;
   localparam int SLOT_S        = 3;
   localparam int SLOT_ADR0     = 4;
   localparam int N_FIXED_SLOTS = 4;

   // bit positions that neighbours decode
   localparam int B_EXT_BIT  = 0;
   localparam int B_NMI_BIT  = 2;
   localparam int P_LSS_BIT  = 7;
   localparam int S_LOCK_BIT = 0;
   localparam int S_USE_BIT  = 1;
   localparam int S_SMAC_BIT = 2;

   // storage and fixed-value masks for the byte-wide registers
   localparam logic [7:0] A_WMASK  = 8'hFF;
   localparam logic [7:0] B_WMASK  = 8'h05;
   localparam logic [7:0] B_FIXED  = 8'h00;
   localparam logic [7:0] P_WMASK  = 8'h80;
   localparam logic [7:0] P_FIXED  = 8'h20;
   localparam logic [7:0] S_WMASK  = 8'h07;
   localparam logic [7:0] S_STICKY = 8'h01;

   localparam int PROT_CTL_W = 3;

   function automatic int prot_width(input int adr_bytes, input int dw);
      return PROT_CTL_W + adr_bytes * dw;
   endfunction
endpackage

// File: rtl/cfg_field_reg.sv
module cfg_field_reg #(
   parameter int           W      = 8,
   parameter logic [W-1:0] RST    = '0,
   parameter logic [W-1:0] WMASK  = '1,
   parameter logic [W-1:0] FIXED  = '0,
   parameter logic [W-1:0] STICKY = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] we,
   input  logic [W-1:0] wd,
   output logic [W-1:0] q_rd
);
   logic [W-1:0] q;

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic bit_q;
      if (STICKY[b]) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= RST[b];
            else if (we[b])
               bit_q <= bit_q | wd[b];
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= RST[b];
            else if (we[b])
               bit_q <= wd[b];
         end
      end
      assign q[b] = bit_q;
   end

   // reserved positions never expose their flop
   assign q_rd = (q & WMASK) | (FIXED & ~WMASK);
endmodule

// File: rtl/cfg_map_decode.sv
module cfg_map_decode #(
   parameter int                          IW       = 8,
   parameter int                          NSLOT    = 4,
   parameter logic [NSLOT-1:0][IW-1:0]    SLOT_IDX = '0,
   parameter logic [NSLOT-1:0]            GATED    = '0
) (
   input  logic [IW-1:0]    idx,
   input  logic             wr,
   input  logic             rd,
   input  logic             map_en,
   output logic [NSLOT-1:0] wr_hit,
   output logic [NSLOT-1:0] rd_hit
);
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      for (genvar t = s + 1; t < NSLOT; t++) begin : g_dup
         if (SLOT_IDX[s] == SLOT_IDX[t]) begin : g_bad
            $error("cfg_map_decode: two slots share one index");
         end
      end
      logic hit;
      assign hit       = (idx == SLOT_IDX[s]) && (!GATED[s] || map_en);
      assign wr_hit[s] = wr && hit;
      assign rd_hit[s] = rd && hit;
   end
endmodule

// File: rtl/cfg_smm_block.sv
module cfg_smm_block
   import cfg_pkg::*;
#(
   parameter int DW         = 8,
   parameter int ADDR_BYTES = 4,
   parameter int PROT_W     = prot_width(ADDR_BYTES, DW)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ctl_wr,
   input  logic [ADDR_BYTES-1:0]           adr_wr,
   input  logic [DW-1:0]                   wdata,
   input  logic                            in_smm,
   output logic [DW-1:0]                   ctl_rd,
   output logic [ADDR_BYTES-1:0][DW-1:0]   adr_rd,
   output logic [PROT_W-1:0]               prot
);
   if (PROT_W != prot_width(ADDR_BYTES, DW)) begin : g_bad_w
      $error("cfg_smm_block: PROT_W does not match the field layout");
   end

   logic          allow;
   logic [DW-1:0] ctl_we;

   // protected fields open when unlocked or when the core is in SMM
   assign allow = !ctl_rd[S_LOCK_BIT] || in_smm;

   always_comb begin
      ctl_we             = {DW{ctl_wr && allow}};
      ctl_we[S_LOCK_BIT] = ctl_wr;
   end

   cfg_field_reg #(
      .W      (DW),
      .RST    ('0),
      .WMASK  (DW'(S_WMASK)),
      .FIXED  ('0),
      .STICKY (DW'(S_STICKY))
   ) ctl_reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_we),
      .wd    (wdata),
      .q_rd  (ctl_rd)
   );

   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_adr
      logic [DW-1:0] byte_we;
      assign byte_we = {DW{adr_wr[i] && allow}};
      cfg_field_reg #(
         .W      (DW),
         .RST    ('0),
         .WMASK  ('1),
         .FIXED  ('0),
         .STICKY ('0)
      ) adr_reg_i (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (byte_we),
         .wd    (wdata),
         .q_rd  (adr_rd[i])
      );
   end

   assign prot = {ctl_rd[S_LOCK_BIT], ctl_rd[S_SMAC_BIT], ctl_rd[S_USE_BIT], adr_rd};
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
   import cfg_pkg::*;
#(
   parameter int            IW          = 8,
   parameter int            DW          = 8,
   parameter int            ADDR_BYTES  = 4,
   parameter logic [IW-1:0] RECOV_IDX   = 8'hE8,
   parameter logic [IW-1:0] NMI_IDX     = 8'hEB,
   parameter logic [IW-1:0] PERF_IDX    = 8'h20,
   parameter logic [IW-1:0] SMM_CTL_IDX = 8'hC1,
   parameter logic [IW-1:0] SMM_ADR_IDX = 8'hC4,
   parameter logic [DW-1:0] RECOV_RST   = 8'h85,
   parameter logic [DW-1:0] NMI_RST     = 8'h00,
   parameter logic [DW-1:0] PERF_RST    = 8'h07,
   localparam int           PROT_W      = prot_width(ADDR_BYTES, DW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IW-1:0]     cfg_idx,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [DW-1:0]     cfg_wdata,
   input  logic              map_en,
   input  logic              in_smm,
   output logic [DW-1:0]     cfg_rdata,
   output logic [DW-1:0]     recov_ctl,
   output logic              ext_en,
   output logic              ls_serial,
   output logic              nmi_req,
   output logic [PROT_W-1:0] smm_prot
);
   localparam int NSLOT = N_FIXED_SLOTS + ADDR_BYTES;

   typedef logic [NSLOT-1:0][IW-1:0] idx_tab_t;

   function automatic idx_tab_t slot_map();
      idx_tab_t m;
      m = '0;
      m[SLOT_A] = RECOV_IDX;
      m[SLOT_B] = NMI_IDX;
      m[SLOT_P] = PERF_IDX;
      m[SLOT_S] = SMM_CTL_IDX;
      for (int i = 0; i < ADDR_BYTES; i++)
         m[SLOT_ADR0 + i] = SMM_ADR_IDX + IW'(i);
      return m;
   endfunction

   localparam idx_tab_t         SLOT_IDX = slot_map();
   localparam logic [NSLOT-1:0] GATE     = NSLOT'((1 << SLOT_A) | (1 << SLOT_B) | (1 << SLOT_P));

   if (DW != 8) begin : g_bad_dw
      $error("cfg_regbank: field layout needs DW == 8");
   end
   if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_ab
      $error("cfg_regbank: ADDR_BYTES must be 1 to 4");
   end
   if (IW < 6) begin : g_bad_iw
      $error("cfg_regbank: IW too narrow for the index map");
   end

   logic [NSLOT-1:0]               wr_hit;
   logic [NSLOT-1:0]               rd_hit;
   logic [NSLOT-1:0][DW-1:0]       rv;
   logic [ADDR_BYTES-1:0][DW-1:0]  adr_rd;
   logic [DW-1:0]                  s_rd;

   cfg_map_decode #(
      .IW       (IW),
      .NSLOT    (NSLOT),
      .SLOT_IDX (SLOT_IDX),
      .GATED    (GATE)
   ) dec_i (
      .idx    (cfg_idx),
      .wr     (cfg_wr),
      .rd     (cfg_rd),
      .map_en (map_en),
      .wr_hit (wr_hit),
      .rd_hit (rd_hit)
   );

   cfg_field_reg #(
      .W      (DW),
      .RST    (RECOV_RST),
      .WMASK  (DW'(A_WMASK)),
      .FIXED  ('0),
      .STICKY ('0)
   ) recov_reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    ({DW{wr_hit[SLOT_A]}}),
      .wd    (cfg_wdata),
      .q_rd  (rv[SLOT_A])
   );

   cfg_field_reg #(
      .W      (DW),
      .RST    (NMI_RST),
      .WMASK  (DW'(B_WMASK)),
      .FIXED  (DW'(B_FIXED)),
      .STICKY ('0)
   ) nmi_reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    ({DW{wr_hit[SLOT_B]}}),
      .wd    (cfg_wdata),
      .q_rd  (rv[SLOT_B])
   );

   cfg_field_reg #(
      .W      (DW),
      .RST    (PERF_RST),
      .WMASK  (DW'(P_WMASK)),
      .FIXED  (DW'(P_FIXED)),
      .STICKY ('0)
   ) perf_reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    ({DW{wr_hit[SLOT_P]}}),
      .wd    (cfg_wdata),
      .q_rd  (rv[SLOT_P])
   );

   cfg_smm_block #(
      .DW         (DW),
      .ADDR_BYTES (ADDR_BYTES),
      .PROT_W     (PROT_W)
   ) smm_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_wr (wr_hit[SLOT_S]),
      .adr_wr (wr_hit[NSLOT-1:SLOT_ADR0]),
      .wdata  (cfg_wdata),
      .in_smm (in_smm),
      .ctl_rd (s_rd),
      .adr_rd (adr_rd),
      .prot   (smm_prot)
   );

   assign rv[SLOT_S] = s_rd;
   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_rv_adr
      assign rv[SLOT_ADR0 + i] = adr_rd[i];
   end

   always_comb begin
      cfg_rdata = '0;
      for (int s = 0; s < NSLOT; s++)
         if (rd_hit[s])
            cfg_rdata = cfg_rdata | rv[s];
   end

   // request only on an accepted 0-to-1 change of the stored bit
   assign nmi_req   = wr_hit[SLOT_B] && cfg_wdata[B_NMI_BIT] && !rv[SLOT_B][B_NMI_BIT];
   assign recov_ctl = rv[SLOT_A];
   assign ext_en    = rv[SLOT_B][B_EXT_BIT];
   assign ls_serial = rv[SLOT_P][P_LSS_BIT];
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
   parameter int            IW        = 8,
   parameter int            DW        = 8,
   parameter int            PROT_W    = 35,
   parameter logic [IW-1:0] RECOV_IDX = 8'hE8,
   parameter logic [IW-1:0] NMI_IDX   = 8'hEB,
   parameter logic [IW-1:0] PERF_IDX  = 8'h20
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IW-1:0]     cfg_idx,
   input logic              cfg_wr,
   input logic              cfg_rd,
   input logic [DW-1:0]     cfg_wdata,
   input logic              map_en,
   input logic              in_smm,
   input logic [DW-1:0]     cfg_rdata,
   input logic [DW-1:0]     recov_ctl,
   input logic              nmi_req,
   input logic [PROT_W-1:0] smm_prot
);
   logic mapped_idx;
   assign mapped_idx = (cfg_idx == RECOV_IDX) || (cfg_idx == NMI_IDX) || (cfg_idx == PERF_IDX);

   assert_gate_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && !map_en && mapped_idx) |-> (cfg_rdata == '0));

   assert_gate_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !map_en && cfg_idx == RECOV_IDX) |=> $stable(recov_ctl));

   assert_resv_nmi_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && map_en && cfg_idx == NMI_IDX) |-> (cfg_rdata[7:3] == 5'd0 && cfg_rdata[1] == 1'b0));

   assert_resv_perf_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && map_en && cfg_idx == PERF_IDX) |-> (cfg_rdata[6:0] == 7'h20));

   assert_nmi_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |=> !nmi_req);

   assert_nmi_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |-> (cfg_wr && map_en && cfg_idx == NMI_IDX && cfg_wdata[2]));

   assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      smm_prot[PROT_W-1] |=> smm_prot[PROT_W-1]);

   assert_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (smm_prot[PROT_W-1] && !in_smm) |=> $stable(smm_prot));
endmodule

bind cfg_regbank cfg_regbank_chk #(
   .IW        (IW),
   .DW        (DW),
   .PROT_W    (PROT_W),
   .RECOV_IDX (RECOV_IDX),
   .NMI_IDX   (NMI_IDX),
   .PERF_IDX  (PERF_IDX)
) chk_i (.*);

// File: tb/cfg_regbank_tb_top.sv
module cfg_regbank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_idx = '0;
   logic        cfg_wr = 1'b0;
   logic        cfg_rd = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic        map_en = 1'b0;
   logic        in_smm = 1'b0;
   logic [7:0]  cfg_rdata;
   logic [7:0]  recov_ctl;
   logic        ext_en;
   logic        ls_serial;
   logic        nmi_req;
   logic [34:0] smm_prot;

   int n_checks = 0;
   int n_fail   = 0;

   // reference state
   logic [7:0] mA, mB, mP;
   logic       mlock, muse, msmac;
   logic [7:0] madr [4];

   always #10 clk = ~clk;

   cfg_regbank dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_idx   (cfg_idx),
      .cfg_wr    (cfg_wr),
      .cfg_rd    (cfg_rd),
      .cfg_wdata (cfg_wdata),
      .map_en    (map_en),
      .in_smm    (in_smm),
      .cfg_rdata (cfg_rdata),
      .recov_ctl (recov_ctl),
      .ext_en    (ext_en),
      .ls_serial (ls_serial),
      .nmi_req   (nmi_req),
      .smm_prot  (smm_prot)
   );

   task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      mA = 8'h85; mB = 8'h00; mP = 8'h07;
      mlock = 1'b0; muse = 1'b0; msmac = 1'b0;
      for (int i = 0; i < 4; i++) madr[i] = 8'h00;
   endtask

   function automatic logic [7:0] mread(input logic [7:0] i, input logic mp);
      if (i == 8'hE8) return mp ? mA : 8'h00;
      if (i == 8'hEB) return mp ? (mB & 8'h05) : 8'h00;
      if (i == 8'h20) return mp ? ((mP & 8'h80) | 8'h20) : 8'h00;
      if (i == 8'hC1) return {5'b0, msmac, muse, mlock};
      if (i >= 8'hC4 && i <= 8'hC7) return madr[i - 8'hC4];
      return 8'h00;
   endfunction

   task automatic cyc(input string tag, input logic [7:0] i, input logic wr, input logic rd,
                      input logic [7:0] wd, input logic mp, input logic smm);
      logic allow;
      @(negedge clk);
      cfg_idx = i; cfg_wr = wr; cfg_rd = rd; cfg_wdata = wd; map_en = mp; in_smm = smm;
      #2;
      check(tag, "rdata", 64'(cfg_rdata), rd ? 64'(mread(i, mp)) : 64'h0);
      check("R6", "nmi_req", 64'(nmi_req), 64'(wr && mp && i == 8'hEB && wd[2] && !mB[2]));
      check("R3", "recov_ctl", 64'(recov_ctl), 64'(mA));
      check("R4", "ext_en", 64'(ext_en), 64'(mB[0]));
      check("R5", "ls_serial", 64'(ls_serial), 64'(mP[7]));
      check("R9", "smm_prot", 64'(smm_prot), 64'({mlock, msmac, muse, madr[3], madr[2], madr[1], madr[0]}));
      @(posedge clk);
      if (wr) begin
         allow = !mlock || smm;
         if (mp && i == 8'hE8) mA = wd;
         if (mp && i == 8'hEB) mB = wd;
         if (mp && i == 8'h20) mP = wd;
         if (i == 8'hC1) begin
            mlock = mlock | wd[0];
            if (allow) begin muse = wd[1]; msmac = wd[2]; end
         end
         if (i >= 8'hC4 && i <= 8'hC7 && allow) madr[i - 8'hC4] = wd;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0;
      repeat (2) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      cyc("R1", 8'hE8, 0, 1, 8'h00, 1, 0);
      cyc("R1", 8'hEB, 0, 1, 8'h00, 1, 0);
      cyc("R1", 8'h20, 0, 1, 8'h00, 1, 0);
      cyc("R1", 8'hC1, 0, 1, 8'h00, 1, 0);
      for (int k = 0; k < 4; k++) cyc("R1", 8'hC4 + 8'(k), 0, 1, 8'h00, 1, 0);

      // R3 full byte write
      cyc("R3", 8'hE8, 1, 0, 8'h5A, 1, 0);
      cyc("R3", 8'hE8, 0, 1, 8'h00, 1, 0);
      cyc("R3", 8'hE8, 1, 1, 8'hA5, 1, 0);
      cyc("R3", 8'hE8, 0, 1, 8'h00, 1, 0);

      // R2 map gating
      cyc("R2", 8'hE8, 1, 0, 8'hFF, 0, 0);
      cyc("R2", 8'hE8, 0, 1, 8'h00, 0, 0);
      cyc("R2", 8'hE8, 0, 1, 8'h00, 1, 0);
      cyc("R2", 8'hEB, 1, 0, 8'h05, 0, 0);
      cyc("R2", 8'hEB, 0, 1, 8'h00, 1, 0);
      cyc("R2", 8'h20, 1, 0, 8'hFF, 0, 0);
      cyc("R2", 8'h20, 0, 1, 8'h00, 0, 0);
      cyc("R2", 8'h20, 0, 1, 8'h00, 1, 0);

      // R4 reserved bits, R6 pulse rules
      cyc("R4", 8'hEB, 1, 0, 8'hFF, 1, 0);
      cyc("R4", 8'hEB, 0, 1, 8'h00, 1, 0);
      cyc("R6", 8'hEB, 1, 0, 8'h04, 1, 0);
      cyc("R6", 8'hEB, 1, 0, 8'h00, 1, 0);
      cyc("R6", 8'hEB, 1, 0, 8'h04, 1, 0);
      cyc("R6", 8'hEB, 1, 1, 8'h04, 1, 0);
      cyc("R4", 8'hEB, 1, 0, 8'hFA, 1, 0);
      cyc("R4", 8'hEB, 0, 1, 8'h00, 1, 0);

      // R5 performance register
      cyc("R5", 8'h20, 1, 0, 8'hFF, 1, 0);
      cyc("R5", 8'h20, 0, 1, 8'h00, 1, 0);
      cyc("R5", 8'h20, 1, 0, 8'h5F, 1, 0);
      cyc("R5", 8'h20, 0, 1, 8'h00, 1, 0);

      // R10 unknown indices
      cyc("R10", 8'hE9, 1, 0, 8'hFF, 1, 0);
      cyc("R10", 8'hE9, 0, 1, 8'h00, 1, 0);
      cyc("R10", 8'h21, 0, 1, 8'h00, 1, 0);
      cyc("R10", 8'hC8, 1, 1, 8'h77, 1, 1);
      cyc("R10", 8'hE8, 0, 1, 8'h00, 1, 0);

      // R9 protected bus layout, access without map_en
      cyc("R9", 8'hC4, 1, 0, 8'h11, 0, 0);
      cyc("R9", 8'hC5, 1, 0, 8'h22, 0, 0);
      cyc("R9", 8'hC6, 1, 0, 8'h33, 1, 0);
      cyc("R9", 8'hC7, 1, 0, 8'h44, 1, 0);
      cyc("R9", 8'hC1, 1, 0, 8'hFE, 0, 0);
      cyc("R9", 8'hC1, 0, 1, 8'h00, 0, 0);
      cyc("R9", 8'hC7, 0, 1, 8'h00, 0, 0);

      // R7 sticky lock, R8 guard
      cyc("R7", 8'hC1, 1, 0, 8'h01, 0, 0);
      cyc("R7", 8'hC1, 1, 0, 8'h00, 0, 0);
      cyc("R7", 8'hC1, 0, 1, 8'h00, 0, 0);
      cyc("R8", 8'hC4, 1, 0, 8'hFF, 1, 0);
      cyc("R8", 8'hC4, 0, 1, 8'h00, 1, 0);
      cyc("R8", 8'hC7, 1, 1, 8'h00, 1, 0);
      cyc("R8", 8'hC1, 1, 0, 8'h01, 1, 1);
      cyc("R8", 8'hC1, 0, 1, 8'h00, 1, 1);
      cyc("R8", 8'hC4, 1, 0, 8'hAA, 1, 1);
      cyc("R8", 8'hC4, 0, 1, 8'h00, 1, 0);
      cyc("R7", 8'hC1, 1, 0, 8'h06, 1, 1);
      cyc("R7", 8'hC1, 0, 1, 8'h00, 1, 0);
      cyc("R8", 8'hC5, 1, 0, 8'h99, 1, 0);
      cyc("R8", 8'hC5, 0, 1, 8'h00, 1, 0);

      // R7 reset clears the lock, R1 values return
      do_reset();
      cyc("R7", 8'hC1, 0, 1, 8'h00, 1, 0);
      cyc("R1", 8'hE8, 0, 1, 8'h00, 1, 0);
      cyc("R1", 8'h20, 0, 1, 8'h00, 1, 0);
      cyc("R8", 8'hC6, 1, 0, 8'h5C, 1, 0);
      cyc("R8", 8'hC6, 0, 1, 8'h00, 1, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule